// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, made of a segment number and an offset within that segment, into a physical address. It uses a segment table that sits in ordinary memory. Two configuration inputs describe the table: the physical address where it starts and the number of segments it holds.

The unit takes one request at a time. First it checks the segment number against the table size. A segment number that is out of range fails at once, with no memory traffic. Otherwise the unit reads the two-word table entry. The first word is the segment's physical base. The second word holds the segment length in its upper bits, with a valid bit and read, write and execute permission bits below it. The unit then checks the valid bit, the offset against the length and the access type against the permissions. It returns either base plus offset or a fault code.

The response is a single-cycle strobe. A new request can be accepted once the previous one has been answered. The table base and size are sampled when a request is accepted, so software may change them while a lookup is still in progress.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: For a segment number s that is in range, the unit issues exactly two one-cycle memory read pulses. The first goes to table_base + 8*s and returns the base word. The second goes to table_base + 8*s + 4 and returns the length word. Each read waits for `mem_rvalid`, which arrives in a later cycle than the pulse and may arrive after any number of extra cycles.
- R3: A segment number greater than or equal to `tbl_len_i` answers with fault code 1 (segment out of range). It issues no memory read.
- R4: When bit 0 of the length word (the valid bit) is 0, the unit answers with fault code 2 (invalid segment).
- R5: When the offset is greater than or equal to the segment length, the unit answers with fault code 3 (offset beyond length). The segment length is the length word shifted right by 4, which is bits 31:4.
- R6: The access type selects the permission bit of the length word that must be 1. Type 0 is read and uses bit 1, type 1 is write and uses bit 2, and type 2 is execute and uses bit 3. Type 3 always faults. A missing permission answers with fault code 4 (protection).
- R7: When several faults apply, only the first in this order is reported: segment out of range, invalid segment, offset beyond length, protection.
- R8: With no fault, `rsp_fault` is 0 and `rsp_paddr` is the base word plus the zero-extended offset, modulo 2^32.
- R9: `rsp_valid` lasts exactly one cycle per request. `req_ready` is 0 from acceptance until the response has been given. `tbl_base_i` and `tbl_len_i` matter only in the acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base_i | input | 32 | Physical start address of the segment table |
| tbl_len_i | input | 9 | Number of segments in the table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_seg | input | 8 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| mem_req | output | 1 | One-cycle memory read pulse |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | 32 | Translated physical address, meaningful when the fault code is 0 |
| rsp_fault | output | 3 | 0 none, 1 segment range, 2 invalid, 3 length, 4 protection |

## Verification
Requests cover every access type against segments that grant all, some or none of the permissions. This shows that each permission bit is wired to its own access type and that the reserved type is always refused. Offsets are placed at 0, at length minus one, at the length itself and beyond it, and a zero-length segment is included, which exposes off-by-one errors in the length comparison. Other entries combine several faults at once, such as invalid with an oversized offset, or an oversized offset with no permission, to separate the priority order. Further cases use a base near the top of the address space to show wraparound, a second table at another address, and changes to the table inputs right after acceptance. The same requests also run with a slow memory response, so that any capture of read data that does not wait for its strobe shows up.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_SEG     = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LENGTH  = 3'd3,
        FLT_PROT    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_BASE,
        ST_WT_BASE,
        ST_RD_LEN,
        ST_WT_LEN,
        ST_RESP
    } fetch_st_e;

    localparam int VALID_BIT = 0;
    localparam int PERM_R_BIT = 1;
    localparam int PERM_W_BIT = 2;
    localparam int PERM_X_BIT = 3;
    localparam int LEN_LSB = 4;

endpackage

// File: rtl/seg_entry_fetch.sv
module seg_entry_fetch
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 8,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [SEG_W:0]    tbl_len_i,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic              bound_err,
    output logic [ADDR_W-1:0] base_word,
    output logic [ADDR_W-1:0] len_word,
    output logic [OFF_W-1:0]  off,
    output logic [1:0]        acc
);

    localparam int ENTRY_SHIFT = 3;
    localparam logic [ADDR_W-1:0] LEN_WORD_OFS = ADDR_W'(4);

    typedef struct packed {
        fetch_st_e         st;
        logic [SEG_W-1:0]  seg;
        logic [OFF_W-1:0]  off;
        logic [1:0]        acc;
        logic [ADDR_W-1:0] tbl;
        logic              bound;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] len;
    } fetch_t;

    fetch_t f_d, f_q;
    logic [ADDR_W-1:0] entry_addr;

    always_comb begin
        f_d = f_q;
        entry_addr = f_q.tbl + (ADDR_W'(f_q.seg) << ENTRY_SHIFT);
        case (f_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    f_d.seg = req_seg;
                    f_d.off = req_off;
                    f_d.acc = req_acc;
                    f_d.tbl = tbl_base_i;
                    if ({1'b0, req_seg} >= tbl_len_i) begin
                        f_d.bound = 1'b1;
                        f_d.st    = ST_RESP;
                    end else begin
                        f_d.bound = 1'b0;
                        f_d.st    = ST_RD_BASE;
                    end
                end
            end
            ST_RD_BASE: f_d.st = ST_WT_BASE;
            ST_WT_BASE: begin
                if (mem_rvalid) begin
                    f_d.base = mem_rdata;
                    f_d.st   = ST_RD_LEN;
                end
            end
            ST_RD_LEN: f_d.st = ST_WT_LEN;
            ST_WT_LEN: begin
                if (mem_rvalid) begin
                    f_d.len = mem_rdata;
                    f_d.st  = ST_RESP;
                end
            end
            ST_RESP: f_d.st = ST_IDLE;
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{st: ST_IDLE, default: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign req_ready = (f_q.st == ST_IDLE);
    assign mem_req   = (f_q.st == ST_RD_BASE) || (f_q.st == ST_RD_LEN);
    assign mem_addr  = (f_q.st == ST_RD_LEN) ? entry_addr + LEN_WORD_OFS : entry_addr;
    assign done      = (f_q.st == ST_RESP);
    assign bound_err = f_q.bound;
    assign base_word = f_q.base;
    assign len_word  = f_q.len;
    assign off       = f_q.off;
    assign acc       = f_q.acc;

    // R2: each read is a single-cycle pulse
    assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9: after acceptance the unit is busy
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              bound_err,
    input  logic [ADDR_W-1:0] base_word,
    input  logic [ADDR_W-1:0] len_word,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    output logic [2:0]        fault,
    output logic [ADDR_W-1:0] paddr
);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] seg_len;
    logic              perm_ok;
    fault_e            flt;

    always_comb begin
        off_ext = ADDR_W'(off);
        seg_len = len_word >> LEN_LSB;
        case (acc_e'(acc))
            ACC_READ:  perm_ok = len_word[PERM_R_BIT];
            ACC_WRITE: perm_ok = len_word[PERM_W_BIT];
            ACC_EXEC:  perm_ok = len_word[PERM_X_BIT];
            default:   perm_ok = 1'b0;
        endcase
        if (bound_err)                  flt = FLT_SEG;
        else if (!len_word[VALID_BIT])  flt = FLT_INVALID;
        else if (off_ext >= seg_len)    flt = FLT_LENGTH;
        else if (!perm_ok)              flt = FLT_PROT;
        else                            flt = FLT_NONE;
        fault = flt;
        paddr = base_word + off_ext;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 8,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [SEG_W:0]    tbl_len_i,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_fault
);

    logic              bound_err;
    logic [ADDR_W-1:0] base_word;
    logic [ADDR_W-1:0] len_word;
    logic [OFF_W-1:0]  off;
    logic [1:0]        acc;

    seg_entry_fetch #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .OFF_W(OFF_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tbl_base_i (tbl_base_i),
        .tbl_len_i  (tbl_len_i),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_seg    (req_seg),
        .req_off    (req_off),
        .req_acc    (req_acc),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .done       (rsp_valid),
        .bound_err  (bound_err),
        .base_word  (base_word),
        .len_word   (len_word),
        .off        (off),
        .acc        (acc)
    );

    seg_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_check (
        .bound_err (bound_err),
        .base_word (base_word),
        .len_word  (len_word),
        .off       (off),
        .acc       (acc),
        .fault     (rsp_fault),
        .paddr     (rsp_paddr)
    );

    // Read pulses counted since the last acceptance, for the checks below
    logic [1:0] rd_cnt_d, rd_cnt_q;

    always_comb begin
        rd_cnt_d = rd_cnt_q;
        if (req_valid && req_ready) rd_cnt_d = '0;
        else if (mem_req && rd_cnt_q != 2'd3) rd_cnt_d = rd_cnt_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_cnt_q <= '0;
        else        rd_cnt_q <= rd_cnt_d;
    end

    assert_no_read_on_range_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_SEG) |-> rd_cnt_q == 2'd0);

    assert_two_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_SEG) |-> rd_cnt_q == 2'd2);

    assert_single_cycle_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_fault_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault <= 3'd4);

endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbl_base_i = '0;
    logic [8:0]  tbl_len_i = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .tbl_base_i(tbl_base_i), .tbl_len_i(tbl_len_i),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // scoreboard queues
    logic [2:0]  q_fault[$];
    logic [31:0] q_paddr[$];
    string       q_tag[$];

    // memory model
    logic [31:0] mem [0:255];
    int          extra_lat = 0;
    bit          pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] paddr_l = '0;
    int          rd_seen = 0;

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend) begin
            if (pcnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[paddr_l[9:2]];
                pend = 1'b0;
            end else begin
                pcnt = pcnt - 1;
            end
        end
        if (mem_req) begin
            pend = 1'b1;
            pcnt = extra_lat;
            paddr_l = mem_addr;
            rd_seen = rd_seen + 1;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            logic [2:0]  ef;
            logic [31:0] ep;
            string       tg;
            int          ereads;
            if (q_fault.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R9 unexpected response: actual fault %0d expected none pending", rsp_fault);
            end else begin
                ef = q_fault.pop_front();
                ep = q_paddr.pop_front();
                tg = q_tag.pop_front();
                ereads = (ef == 3'd1) ? 0 : 2;
                n_checks++;
                if (rsp_fault !== ef) begin
                    n_fail++;
                    $display("FAIL %s fault: actual %0d expected %0d", tg, rsp_fault, ef);
                end
                if (ef == 3'd0) begin
                    n_checks++;
                    if (rsp_paddr !== ep) begin
                        n_fail++;
                        $display("FAIL %s paddr: actual %h expected %h", tg, rsp_paddr, ep);
                    end
                end
                n_checks++;
                if (rd_seen != ereads) begin
                    n_fail++;
                    $display("FAIL R2/R3 (%s) reads: actual %0d expected %0d", tg, rd_seen, ereads);
                end
                n_checks++;
                if (req_ready !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R9 (%s) ready during response: actual %b expected 0", tg, req_ready);
                end
            end
            rd_seen = 0;
        end
    end

    task automatic do_req(input logic [31:0] tb, input logic [8:0] tl, input logic [7:0] s,
                          input logic [15:0] o, input logic [1:0] a,
                          input logic [2:0] ef, input logic [31:0] ep, input string tg);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        q_fault.push_back(ef);
        q_paddr.push_back(ep);
        q_tag.push_back(tg);
        tbl_base_i = tb;
        tbl_len_i  = tl;
        req_seg = s; req_off = o; req_acc = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R9: table inputs after acceptance must have no effect
        tbl_base_i = 32'hDEAD_0000;
        tbl_len_i  = 9'd0;
        req_seg = 8'hFF; req_off = 16'hFFFF; req_acc = 2'd3;
    endtask

    task automatic run_set;
        localparam logic [31:0] T1 = 32'h100;
        // R8 success cases, each access type
        do_req(T1, 9'd7, 8'd0, 16'h0000, 2'd0, 3'd0, 32'h0001_0000, "R8 read off 0");
        do_req(T1, 9'd7, 8'd0, 16'h00FF, 2'd1, 3'd0, 32'h0001_00FF, "R5 last in-range offset");
        do_req(T1, 9'd7, 8'd0, 16'h0042, 2'd2, 3'd0, 32'h0001_0042, "R6 exec allowed");
        do_req(T1, 9'd7, 8'd0, 16'h0100, 2'd0, 3'd3, 32'h0, "R5 offset equals length");
        do_req(T1, 9'd7, 8'd0, 16'h0010, 2'd3, 3'd4, 32'h0, "R6 reserved type");
        // seg1: read only
        do_req(T1, 9'd7, 8'd1, 16'h003F, 2'd0, 3'd0, 32'h2000_003F, "R6 read-only read");
        do_req(T1, 9'd7, 8'd1, 16'h0001, 2'd1, 3'd4, 32'h0, "R6 read-only write");
        do_req(T1, 9'd7, 8'd1, 16'h0001, 2'd2, 3'd4, 32'h0, "R6 read-only exec");
        // seg2 invalid
        do_req(T1, 9'd7, 8'd2, 16'h0001, 2'd0, 3'd2, 32'h0, "R4 invalid segment");
        // seg3 wrap, exec only
        do_req(T1, 9'd7, 8'd3, 16'h0180, 2'd2, 3'd0, 32'h0000_0080, "R8 wraparound");
        do_req(T1, 9'd7, 8'd3, 16'h0180, 2'd0, 3'd4, 32'h0, "R6 exec-only read");
        // seg4 zero length
        do_req(T1, 9'd7, 8'd4, 16'h0000, 2'd0, 3'd3, 32'h0, "R5 zero length");
        // priorities
        do_req(T1, 9'd7, 8'd5, 16'h0400, 2'd3, 3'd2, 32'h0, "R7 invalid over length");
        do_req(T1, 9'd7, 8'd6, 16'h0020, 2'd0, 3'd3, 32'h0, "R7 length over protection");
        do_req(T1, 9'd7, 8'd6, 16'h0005, 2'd1, 3'd4, 32'h0, "R6 no permissions");
        // range
        do_req(T1, 9'd7, 8'd7, 16'h0000, 2'd0, 3'd1, 32'h0, "R3 seg equals length");
        do_req(T1, 9'd7, 8'd200, 16'h0000, 2'd0, 3'd1, 32'h0, "R3 seg far out");
        do_req(T1, 9'd0, 8'd0, 16'h0000, 2'd0, 3'd1, 32'h0, "R3 empty table");
        // second table
        do_req(32'h200, 9'd1, 8'd0, 16'h007F, 2'd1, 3'd0, 32'h0000_307F, "R2 second table");
        do_req(32'h200, 9'd1, 8'd0, 16'h0080, 2'd1, 3'd3, 32'h0, "R5 second table length");
        do_req(32'h200, 9'd1, 8'd1, 16'h0000, 2'd1, 3'd1, 32'h0, "R3 second table range");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        // table at 0x100 : word index 64 + 2*s
        mem[64] = 32'h0001_0000; mem[65] = 32'h0000_100F; // seg0 len 0x100 VRWX
        mem[66] = 32'h2000_0000; mem[67] = 32'h0000_0403; // seg1 len 0x40 VR
        mem[68] = 32'h0005_0000; mem[69] = 32'h0000_010E; // seg2 invalid
        mem[70] = 32'hFFFF_FF00; mem[71] = 32'h0000_2009; // seg3 len 0x200 VX
        mem[72] = 32'h0006_0000; mem[73] = 32'h0000_0007; // seg4 len 0 VRW
        mem[74] = 32'h0007_0000; mem[75] = 32'h0000_0010; // seg5 len 1 invalid
        mem[76] = 32'h0008_0000; mem[77] = 32'h0000_0101; // seg6 len 0x10 V only
        // table at 0x200 : word index 128
        mem[128] = 32'h0000_3000; mem[129] = 32'h0000_0805; // len 0x80 VW

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        n_checks++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual ready %b rsp %b req %b expected 1 0 0",
                     req_ready, rsp_valid, mem_req);
        end
        rst_n = 1'b1;

        extra_lat = 0;
        run_set();
        extra_lat = 3;
        run_set();

        while (q_fault.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule